// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs one external memory bus cycle at a time on behalf of an internal requester. A request carries an address, a read/write select and write data. Once the block has taken a request, it drives the external address, the write data with its output enable, and an active-low read or write strobe. It holds them for a programmed minimum number of wait states. An external active-low acknowledge can stretch the cycle further, with no upper limit. When the cycle ends, read data is captured and a one-clock done pulse is returned.

The length of the cycle is whichever is longer: the programmed minimum, or the point the acknowledge allows. A programmed count of zero gives a single-clock cycle and the acknowledge is not consulted. The acknowledge is resynchronised through a flop chain before use. It counts only while the block owns the bus and a cycle is under way. One clock runs the whole block and stands in for the bus output clock.

Top module: `ebus_wait_ctl`

## Requirements
- R1: After reset, both strobes are high (inactive), `ext_data_oe` is 0, `rsp_done` is 0, and `req_ready` equals `bus_owner`.
- R2: With programmed count N ≥ 1 and acknowledge held low throughout, the strobe is active for exactly N+1 clocks.
- R3: Suppose N ≥ 1 and acknowledge goes low during the k-th active strobe clock, having been high beforehand. The strobe is then active for max(N+1, k+2) clocks (two synchroniser stages). Any k is allowed, so a cycle can be stretched without limit.
- R4: With N = 0 the strobe is active for exactly one clock whatever the level of acknowledge, including acknowledge held high (deasserted).
- R5: While `bus_owner` is 0, the acknowledge is ignored and an active cycle with N ≥ 1 does not end. Once `bus_owner` returns to 1 with acknowledge held low, the cycle ends at the next edge.
- R6: An acknowledge pulse seen while no cycle is in progress has no effect on a later cycle's length.
- R7: On the edge that ends a read, `ext_rdata` is captured into `rsp_rdata`. `rsp_done` is high for exactly the one clock following that edge.
- R8: `req_ready` is 0 while a strobe is active and while `bus_owner` is 0. A request is accepted only on an edge where `req_valid` and `req_ready` are both 1.
- R9: A read drives `ext_rd_n` low, and a write drives `ext_wr_n` low with `ext_data_oe` high. The two strobes are never low together. Address and write data stay stable for the whole cycle. Both strobes are high in the clock in which `rsp_done` is high, so back-to-back cycles are separated by at least one inactive clock.
- R10: Asserting `rst_n` low during a cycle at once returns both strobes high, `ext_data_oe` to 0 and `rsp_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester has a cycle to run |
| req_ready | output | 1 | Block can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| ws_count | input | WS_W | Programmed minimum wait states |
| bus_owner | input | 1 | Block currently owns the external bus |
| ack_n | input | 1 | Asynchronous active-low transfer acknowledge |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | DATA_W | External write data |
| ext_data_oe | output | 1 | Write data output enable |
| ext_rdata | input | DATA_W | External read data |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_done | output | 1 | One-clock completion pulse |

## Verification
The properties assume that `ws_count` does not change between a request's acceptance and its done pulse. They also assume that `ack_n` starts high before each stretched cycle. The stimulus therefore sets the count before raising `req_valid`, and before every acknowledge-stretched cycle it releases the acknowledge for three idle clocks, after one stray idle-time pulse. Ownership is dropped only inside a dedicated sequence, and random cycles mix held acknowledge, late acknowledge and zero-wait counts.

// File: rtl/ebus_wait_pkg.sv
package ebus_wait_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACTIVE = 1'b1
   } ebus_state_e;
endpackage

// File: rtl/ebus_ack_sync.sv
module ebus_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_async,
   output logic ack_sync
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("ebus_ack_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= ~ack_n_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign ack_sync = chain[LAST];
endmodule

// File: rtl/ebus_ws_counter.sv
module ebus_ws_counter #(
   parameter int WS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [WS_W-1:0] ws_in,
   input  logic            step,
   output logic            cnt_zero,
   output logic            ws_zero
);
   localparam logic [WS_W-1:0] ONE = {{(WS_W-1){1'b0}}, 1'b1};

   if (WS_W < 1 || WS_W > 16) begin : g_bad_width
      $error("ebus_ws_counter: WS_W must be 1..16");
   end

   logic [WS_W-1:0] cnt;
   logic            zero_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         zero_lat <= 1'b1;
      end else if (load) begin
         cnt      <= ws_in;
         zero_lat <= (ws_in == '0);
      end else if (step && cnt != '0) begin
         cnt <= cnt - ONE;
      end
   end

   assign cnt_zero = (cnt == '0);
   assign ws_zero  = zero_lat;
endmodule

// File: rtl/ebus_cycle_fsm.sv
module ebus_cycle_fsm
   import ebus_wait_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bus_owner,
   input  logic              ack_sync,
   input  logic              cnt_zero,
   input  logic              ws_zero,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              req_ready,
   output logic              accept,
   output logic              cyc_active,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   output logic              ext_data_oe,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done
);
   ebus_state_e state;
   logic        finish;
   logic        ack_ok;

   assign req_ready  = (state == ST_IDLE) && bus_owner;
   assign accept     = req_ready && req_valid;
   assign cyc_active = (state == ST_ACTIVE);
   assign ack_ok     = ack_sync && bus_owner;
   assign finish     = cyc_active && cnt_zero && (ws_zero || ack_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         ext_addr    <= '0;
         ext_wdata   <= '0;
         ext_data_oe <= 1'b0;
         ext_rd_n    <= 1'b1;
         ext_wr_n    <= 1'b1;
         rsp_rdata   <= '0;
         rsp_done    <= 1'b0;
      end else begin
         rsp_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state       <= ST_ACTIVE;
                  ext_addr    <= req_addr;
                  ext_wdata   <= req_wdata;
                  ext_data_oe <= req_write;
                  ext_rd_n    <= req_write;
                  ext_wr_n    <= ~req_write;
               end
            end
            ST_ACTIVE: begin
               if (finish) begin
                  state       <= ST_IDLE;
                  ext_data_oe <= 1'b0;
                  ext_rd_n    <= 1'b1;
                  ext_wr_n    <= 1'b1;
                  rsp_done    <= 1'b1;
                  if (!ext_data_oe) rsp_rdata <= ext_rdata;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ebus_wait_ctl.sv
module ebus_wait_ctl #(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 24,
   parameter int WS_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WS_W-1:0]   ws_count,
   input  logic              bus_owner,
   input  logic              ack_n,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   output logic              ext_data_oe,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("ebus_wait_ctl: ADDR_W and DATA_W must be positive");
   end

   logic ack_sync;
   logic cnt_zero;
   logic ws_zero;
   logic accept;
   logic cyc_active;

   ebus_ack_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_n_async (ack_n),
      .ack_sync    (ack_sync)
   );

   ebus_ws_counter #(.WS_W(WS_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .ws_in    (ws_count),
      .step     (cyc_active),
      .cnt_zero (cnt_zero),
      .ws_zero  (ws_zero)
   );

   ebus_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .bus_owner   (bus_owner),
      .ack_sync    (ack_sync),
      .cnt_zero    (cnt_zero),
      .ws_zero     (ws_zero),
      .ext_rdata   (ext_rdata),
      .req_ready   (req_ready),
      .accept      (accept),
      .cyc_active  (cyc_active),
      .ext_addr    (ext_addr),
      .ext_wdata   (ext_wdata),
      .ext_data_oe (ext_data_oe),
      .ext_rd_n    (ext_rd_n),
      .ext_wr_n    (ext_wr_n),
      .rsp_rdata   (rsp_rdata),
      .rsp_done    (rsp_done)
   );
endmodule

// File: rtl/ebus_wait_chk.sv
module ebus_wait_chk #(
   parameter int ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              bus_owner,
   input logic              ext_rd_n,
   input logic              ext_wr_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              rsp_done,
   input logic              cyc_active,
   input logic              cnt_zero,
   input logic              ws_zero
);
   logic strobe_on;
   assign strobe_on = !ext_rd_n || !ext_wr_n;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_rd_n && !ext_wr_n)); // R9
   AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (ext_rd_n && ext_wr_n)); // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_on && $past(strobe_on)) |-> $stable(ext_addr)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R7
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_on |-> !req_ready); // R8
   AST_NO_READY_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_owner |-> !req_ready); // R8
   AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_on && !cnt_zero) |=> strobe_on); // R2
   AST_ZERO_WS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_on && ws_zero) |=> !strobe_on); // R4
   AST_UNOWNED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_active && !ws_zero && !bus_owner) |=> strobe_on); // R5
endmodule

bind ebus_wait_ctl ebus_wait_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .bus_owner  (bus_owner),
   .ext_rd_n   (ext_rd_n),
   .ext_wr_n   (ext_wr_n),
   .ext_addr   (ext_addr),
   .rsp_done   (rsp_done),
   .cyc_active (cyc_active),
   .cnt_zero   (cnt_zero),
   .ws_zero    (ws_zero)
);

// File: tb/ebus_wait_ctl_tb_top.sv
`timescale 1ns/1ps
module ebus_wait_ctl_tb_top;
   localparam int ADDR_W = 18;
   localparam int DATA_W = 24;
   localparam int WS_W   = 4;
   localparam int SYNC   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [WS_W-1:0]   ws_count = '0;
   logic              bus_owner = 1'b1;
   logic              ack_n = 1'b1;
   logic [ADDR_W-1:0] ext_addr;
   logic [DATA_W-1:0] ext_wdata;
   logic              ext_data_oe;
   logic [DATA_W-1:0] ext_rdata = '0;
   logic              ext_rd_n;
   logic              ext_wr_n;
   logic [DATA_W-1:0] rsp_rdata;
   logic              rsp_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ebus_wait_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .ws_count(ws_count), .bus_owner(bus_owner), .ack_n(ack_n),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_data_oe(ext_data_oe),
      .ext_rdata(ext_rdata), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(input int n, input int k);
      if (n == 0) return 1;
      if (k <= 0) return n + 1;
      return (n + 1 > k + SYNC) ? n + 1 : k + SYNC;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // k < 0: ack held low; k == 0: ack held high; k > 0: ack goes low in active clock k
   task automatic do_cycle(input bit wr, input int n, input int k, input string req);
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] rd;
      int active;
      int guard;
      a  = ADDR_W'($urandom);
      d  = DATA_W'($urandom);
      rd = DATA_W'($urandom);
      ws_count = WS_W'(n);
      if (k > 0) begin
         ack_n = 1'b1;
         @(negedge clk);
         ack_n = 1'b0;            // stray idle pulse, R6
         @(negedge clk);
         ack_n = 1'b1;
         repeat (3) @(negedge clk);
      end else if (k < 0) begin
         ack_n = 1'b0;
      end else begin
         ack_n = 1'b1;
      end
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; ext_rdata = rd;
      check(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      active = 0;
      guard  = 0;
      while (!rsp_done && guard < 300) begin
         guard++;
         if (!ext_rd_n || !ext_wr_n) begin
            active++;
            if (active == 1) begin
               check(ext_addr == a, "R9 address", ext_addr, a);
               check(ext_rd_n == wr && ext_wr_n == !wr, "R9 strobe kind", {ext_rd_n, ext_wr_n}, {wr, !wr});
               check(ext_data_oe == wr, "R9 output enable", ext_data_oe, wr);
               if (wr) check(ext_wdata == d, "R9 write data", ext_wdata, d);
               check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
               check(rsp_done == 1'b0, "R7 done single pulse", rsp_done, 0);
            end
            if (k > 0 && active == k) ack_n = 1'b0;
         end else begin
            check(1'b0, "R9 strobe dropped before done", active, -1);
            guard = 300;
         end
         if (guard < 300) @(negedge clk);
      end
      check(active == exp_len(n, k), req, active, exp_len(n, k));
      check(ext_rd_n && ext_wr_n && !ext_data_oe, "R9 strobes off in done clock", {ext_rd_n, ext_wr_n}, 3);
      if (!wr) check(rsp_rdata == rd, "R7 read data capture", rsp_rdata, rd);
      ext_rdata = DATA_W'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int seed;
      int cnt;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ext_rd_n && ext_wr_n, "R1 strobes after reset", {ext_rd_n, ext_wr_n}, 3);
      check(!ext_data_oe && !rsp_done, "R1 oe and done after reset", {ext_data_oe, rsp_done}, 0);
      check(req_ready == bus_owner, "R1 ready follows owner", req_ready, bus_owner);
      bus_owner = 1'b0;
      #1 check(req_ready == 1'b0, "R8 ready low without ownership", req_ready, 0);
      bus_owner = 1'b1;
      @(negedge clk);

      do_cycle(1'b0, 3, -1, "R2 length, held ack, read");
      do_cycle(1'b1, 1, -1, "R2 length, held ack, write");
      do_cycle(1'b0, 0, 0,  "R4 zero wait, ack high");
      do_cycle(1'b1, 0, -1, "R4 zero wait, ack low");
      do_cycle(1'b0, 6, 1,  "R3 programmed count dominates");
      do_cycle(1'b1, 2, 40, "R3 long stretch");
      do_cycle(1'b0, 1, 5,  "R6 idle pulse ignored, R3 stretch");
      do_cycle(1'b0, 15, -1, "R2 maximum count");

      // R5: ownership lost mid-cycle
      ws_count = 4'd3; ack_n = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      bus_owner = 1'b0; ack_n = 1'b0;
      cnt = 0;
      repeat (12) begin
         @(negedge clk);
         if (!ext_rd_n && !rsp_done) cnt++;
      end
      check(cnt == 12, "R5 cycle held while not owner", cnt, 12);
      bus_owner = 1'b1;
      @(negedge clk);
      check(rsp_done == 1'b1, "R5 ends one clock after ownership", rsp_done, 1);
      @(negedge clk);

      // R10: reset mid-cycle
      ws_count = 4'd8; ack_n = 1'b0;
      req_valid = 1'b1; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(!ext_wr_n, "R10 cycle running before reset", ext_wr_n, 0);
      rst_n = 1'b0;
      #1;
      check(ext_rd_n && ext_wr_n && !ext_data_oe && !rsp_done, "R10 reset aborts cycle",
            {ext_rd_n, ext_wr_n, ext_data_oe, rsp_done}, 4'b1100);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 60; i++) begin
         int n;
         int k;
         n = $urandom_range(0, 7);
         case ($urandom_range(0, 2))
            0: k = -1;
            1: k = $urandom_range(1, 12);
            default: k = 0;
         endcase
         if (k == 0 && n != 0) k = -1;
         do_cycle(1'(($urandom_range(0, 1))), n, k, (k > 0) ? "R3 random stretch" : "R2 random length");
      end
      finish_run();
   end
endmodule